// File: doc/BRIEF.md
# BCD-Capable Accumulator Execution Unit

This block is the arithmetic heart of a small 8-bit controller. It holds one accumulator register and two flags: carry, and auxiliary carry, which is the carry between the two 4-bit digits. On each cycle where the execute strobe is high it applies one operation, chosen by an operation code, to the accumulator and, for two-input operations, to an operand byte. Operand bytes come from the surrounding datapath: immediates, registers or memory. The operations are: binary add with or without carry-in; the bitwise logic operations; increment, decrement, clear and complement; four rotate forms; a digit swap; a low-digit exchange with a memory operand; and a decimal adjust that repairs the binary sum of two packed BCD numbers.

There is no subtract operation. Software forms A minus B as complement, add B, complement. The zero output is derived directly from the accumulator value, so a branch unit testing it sees the current accumulator, not a remembered flag. For the low-digit exchange, the block drives the byte to be written back to memory, so the caller can store it in the same cycle.

Top module: `bcd_acc_alu`

## Requirements
- R1: After reset the accumulator is 00h, carry and auxiliary carry are 0 and zero is 1.
- R2: While exec_en is low, or when op is NOP (code 0), the accumulator and both flags keep their values.
- R3: ADD (code 2) loads A+operand and ADDC (code 3) loads A+operand+carry, both modulo 256. Carry takes the carry out of bit 7 and auxiliary carry takes the carry out of bit 3. ADD ignores the old carry.
- R4: LOAD (code 1) copies the operand. AND (code 4), OR (code 5) and XOR (code 6) combine the accumulator with the operand bitwise.
- R5: INC (code 7) and DEC (code 8) wrap modulo 256. CLR (code 9) gives 00h and CPL (code 10) gives the ones' complement.
- R6: LOAD, the logic operations, INC, DEC, CLR, CPL, SWAP, XCHD and the carry-less rotates leave carry and auxiliary carry unchanged.
- R7: RL (code 13) and RR (code 15) rotate the 8 bits by one place. RLC (code 14) and RRC (code 16) rotate through carry as a 9-bit loop: RLC moves bit 7 into carry and the old carry into bit 0, and RRC moves bit 0 into carry and the old carry into bit 7.
- R8: SWAP (code 12) exchanges bits 7:4 and 3:0 of the accumulator.
- R9: XCHD (code 17) puts operand bits 3:0 into accumulator bits 3:0 and keeps accumulator bits 7:4. The output xchg_out always equals {operand[7:4], accumulator[3:0]}.
- R10: DA (code 11) adds 06h when the low digit is above 9 or auxiliary carry is set. It then adds 60h when the resulting high digit is above 9, carry is set, or the first step overflowed. Carry is set by any overflow and is never cleared by DA.
- R11: The zero output is 1 exactly when the accumulator currently holds 00h.
- R12: The sequence CPL, ADD B, CPL leaves A minus B modulo 256 in the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Apply op on this edge |
| op | input | 5 | Operation code |
| operand | input | 8 | Second operand byte |
| acc | output | 8 | Accumulator |
| carry | output | 1 | Carry flag |
| aux_carry | output | 1 | Carry between digits |
| zero | output | 1 | Accumulator equals zero |
| xchg_out | output | 8 | Write-back byte for XCHD |

## Verification
The bench builds the block with its default of two BCD digits, an 8-bit accumulator. At that width the digit-boundary carry, the carry out of the top, and both decimal-adjust corrections can all be driven from one byte. The sums 99h+99h and 58h+46h reach the cases where adjustment overflows. The ADD-then-ADDC pair shows that the carry-in is used by one form and ignored by the other. Byte values such as 81h put a 1 at both ends of the word, so every rotate moves a 1 across the word boundary and through carry.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
    localparam int DIGIT_W = 4;
    localparam int OP_W    = 5;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 5'd0,
        OP_LOAD = 5'd1,
        OP_ADD  = 5'd2,
        OP_ADDC = 5'd3,
        OP_AND  = 5'd4,
        OP_OR   = 5'd5,
        OP_XOR  = 5'd6,
        OP_INC  = 5'd7,
        OP_DEC  = 5'd8,
        OP_CLR  = 5'd9,
        OP_CPL  = 5'd10,
        OP_DA   = 5'd11,
        OP_SWAP = 5'd12,
        OP_RL   = 5'd13,
        OP_RLC  = 5'd14,
        OP_RR   = 5'd15,
        OP_RRC  = 5'd16,
        OP_XCHD = 5'd17
    } alu_op_e;
endpackage

// File: rtl/digit_adder.sv
module digit_adder
    import bcd_alu_pkg::*;
(
    input  logic [DIGIT_W-1:0] a,
    input  logic [DIGIT_W-1:0] b,
    input  logic               cin,
    output logic [DIGIT_W-1:0] sum,
    output logic               cout
);
    logic [DIGIT_W:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
        sum  = wide[DIGIT_W-1:0];
        cout = wide[DIGIT_W];
    end
endmodule

// File: rtl/decimal_adjust.sv
module decimal_adjust
    import bcd_alu_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input  logic [DIGITS*DIGIT_W-1:0] acc_in,
    input  logic                      c_in,
    input  logic                      ac_in,
    output logic [DIGITS*DIGIT_W-1:0] acc_out,
    output logic                      c_out
);
    localparam int W = DIGITS * DIGIT_W;
    localparam logic [W:0] SIX = (W+1)'(6);

    logic [W:0] stage [0:DIGITS];

    assign stage[0] = {1'b0, acc_in};

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic             flag;
        logic             fix;
        logic [DIGIT_W-1:0] dig;

        if (DIGITS == 1) begin : g_only
            assign flag = ac_in | c_in;
        end else if (i == 0) begin : g_low
            assign flag = ac_in;
        end else if (i == DIGITS - 1) begin : g_top
            assign flag = c_in | stage[i][W];
        end else begin : g_mid
            assign flag = 1'b0;
        end

        assign dig = stage[i][i*DIGIT_W +: DIGIT_W];
        assign fix = (dig > 4'd9) | flag;
        assign stage[i+1] = stage[i] + (fix ? (SIX << (i*DIGIT_W)) : '0);
    end

    assign acc_out = stage[DIGITS][W-1:0];
    assign c_out   = c_in | stage[DIGITS][W];
endmodule

// File: rtl/rotate_unit.sv
module rotate_unit
    import bcd_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         c_in,
    input  alu_op_e      sel,
    output logic [W-1:0] res,
    output logic         c_out
);
    localparam int HALF = W / 2;

    always_comb begin
        res   = a;
        c_out = c_in;
        unique case (sel)
            OP_RL:   res = {a[W-2:0], a[W-1]};
            OP_RR:   res = {a[0], a[W-1:1]};
            OP_RLC: begin
                res   = {a[W-2:0], c_in};
                c_out = a[W-1];
            end
            OP_RRC: begin
                res   = {c_in, a[W-1:1]};
                c_out = a[0];
            end
            OP_SWAP: res = {a[HALF-1:0], a[W-1:HALF]};
            default: ;
        endcase
    end
endmodule

// File: rtl/bcd_acc_alu.sv
module bcd_acc_alu
    import bcd_alu_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      exec_en,
    input  logic [OP_W-1:0]           op,
    input  logic [DIGITS*DIGIT_W-1:0] operand,
    output logic [DIGITS*DIGIT_W-1:0] acc,
    output logic                      carry,
    output logic                      aux_carry,
    output logic                      zero,
    output logic [DIGITS*DIGIT_W-1:0] xchg_out
);
    localparam int W = DIGITS * DIGIT_W;

    typedef struct packed {
        logic [W-1:0] acc;
        logic         c;
        logic         ac;
    } alu_state_t;

    alu_state_t st_d, st_q;
    alu_op_e    op_sel;

    assign op_sel = alu_op_e'(op);

    // Digit-wise adder chain
    logic [DIGITS:0]  add_cy;
    logic [W-1:0]     add_sum;

    assign add_cy[0] = (op_sel == OP_ADDC) ? st_q.c : 1'b0;

    for (genvar i = 0; i < DIGITS; i++) begin : g_add
        digit_adder u_dig (
            .a   (st_q.acc[i*DIGIT_W +: DIGIT_W]),
            .b   (operand[i*DIGIT_W +: DIGIT_W]),
            .cin (add_cy[i]),
            .sum (add_sum[i*DIGIT_W +: DIGIT_W]),
            .cout(add_cy[i+1])
        );
    end

    logic [W-1:0] da_acc;
    logic         da_c;

    decimal_adjust #(.DIGITS(DIGITS)) u_da (
        .acc_in (st_q.acc),
        .c_in   (st_q.c),
        .ac_in  (st_q.ac),
        .acc_out(da_acc),
        .c_out  (da_c)
    );

    logic [W-1:0] rot_acc;
    logic         rot_c;

    rotate_unit #(.W(W)) u_rot (
        .a    (st_q.acc),
        .c_in (st_q.c),
        .sel  (op_sel),
        .res  (rot_acc),
        .c_out(rot_c)
    );

    always_comb begin
        st_d = st_q;
        if (exec_en) begin
            unique case (op_sel)
                OP_LOAD: st_d.acc = operand;
                OP_ADD, OP_ADDC: begin
                    st_d.acc = add_sum;
                    st_d.c   = add_cy[DIGITS];
                    st_d.ac  = add_cy[1];
                end
                OP_AND:  st_d.acc = st_q.acc & operand;
                OP_OR:   st_d.acc = st_q.acc | operand;
                OP_XOR:  st_d.acc = st_q.acc ^ operand;
                OP_INC:  st_d.acc = st_q.acc + W'(1);
                OP_DEC:  st_d.acc = st_q.acc - W'(1);
                OP_CLR:  st_d.acc = '0;
                OP_CPL:  st_d.acc = ~st_q.acc;
                OP_DA: begin
                    st_d.acc = da_acc;
                    st_d.c   = da_c;
                end
                OP_RL, OP_RR, OP_RLC, OP_RRC, OP_SWAP: begin
                    st_d.acc = rot_acc;
                    st_d.c   = rot_c;
                end
                OP_XCHD: st_d.acc = {st_q.acc[W-1:DIGIT_W], operand[DIGIT_W-1:0]};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc       = st_q.acc;
    assign carry     = st_q.c;
    assign aux_carry = st_q.ac;
    assign zero      = (st_q.acc == '0);
    assign xchg_out  = {operand[W-1:DIGIT_W], st_q.acc[DIGIT_W-1:0]};

    // Assertions
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> ($stable(acc) && $stable(carry) && $stable(aux_carry)));

    assert_flags_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && (op_sel inside {OP_LOAD, OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC,
                                    OP_CLR, OP_CPL, OP_SWAP, OP_XCHD, OP_RL, OP_RR}))
        |=> ($stable(carry) && $stable(aux_carry)));

    assert_rlc_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_sel == OP_RLC) |=> (carry == $past(acc[W-1]) && acc[0] == $past(carry)));

    assert_rrc_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_sel == OP_RRC) |=> (carry == $past(acc[0]) && acc[W-1] == $past(carry)));

    assert_swap_halves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_sel == OP_SWAP) |=> (acc == {$past(acc[W/2-1:0]), $past(acc[W-1:W/2])}));

    assert_xchd_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_sel == OP_XCHD) |=> (acc[W-1:DIGIT_W] == $past(acc[W-1:DIGIT_W])));

    assert_da_carry_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_sel == OP_DA && carry) |=> carry);

    assert_clr_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op_sel == OP_CLR) |=> zero);
endmodule

// File: tb/tb_bcd_acc_alu.sv
`timescale 1ns/1ps
module tb_bcd_acc_alu;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_en = 1'b0;
    logic [4:0] op = 5'd0;
    logic [7:0] operand = 8'h00;
    logic [7:0] acc;
    logic       carry, aux_carry, zero;
    logic [7:0] xchg_out;

    int checks = 0;
    int errors = 0;

    localparam logic [4:0] C_NOP=0, C_LOAD=1, C_ADD=2, C_ADDC=3, C_AND=4, C_OR=5,
        C_XOR=6, C_INC=7, C_DEC=8, C_CLR=9, C_CPL=10, C_DA=11, C_SWAP=12,
        C_RL=13, C_RLC=14, C_RR=15, C_RRC=16, C_XCHD=17;

    always #10 clk = ~clk;

    bcd_acc_alu dut (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op(op), .operand(operand),
        .acc(acc), .carry(carry), .aux_carry(aux_carry), .zero(zero), .xchg_out(xchg_out)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic run(input logic [4:0] code, input logic [7:0] val, input logic en = 1'b1);
        @(negedge clk);
        op = code; operand = val; exec_en = en;
        @(posedge clk); #1;
        exec_en = 1'b0; op = C_NOP;
    endtask

    task automatic t_reset;
        check("R1 acc", acc, 8'h00);
        check("R1 carry", {7'd0, carry}, 8'h00);
        check("R1 aux", {7'd0, aux_carry}, 8'h00);
        check("R1 zero", {7'd0, zero}, 8'h01);
    endtask

    task automatic t_add;
        run(C_LOAD, 8'hFF);
        run(C_ADD, 8'h01);
        check("R3 add wrap", acc, 8'h00);
        check("R3 carry out", {7'd0, carry}, 8'h01);
        check("R3 aux out", {7'd0, aux_carry}, 8'h01);
        check("R11 zero on 00", {7'd0, zero}, 8'h01);
        run(C_ADDC, 8'h10);
        check("R3 addc uses carry", acc, 8'h11);
        check("R3 addc clears carry", {7'd0, carry}, 8'h00);
        check("R11 zero off", {7'd0, zero}, 8'h00);
        run(C_LOAD, 8'hF0); run(C_ADD, 8'h10);   // carry=1, acc=0
        run(C_ADD, 8'h10);
        check("R3 add ignores carry", acc, 8'h10);
    endtask

    task automatic t_logic;
        run(C_LOAD, 8'hF8); run(C_ADD, 8'h08);   // acc 00, carry 1, aux 1
        run(C_LOAD, 8'hCA);
        check("R4 load", acc, 8'hCA);
        run(C_AND, 8'h0F); check("R4 and", acc, 8'h0A);
        run(C_OR, 8'hA0);  check("R4 or", acc, 8'hAA);
        run(C_XOR, 8'hFF); check("R4 xor", acc, 8'h55);
        check("R6 carry kept", {7'd0, carry}, 8'h01);
        check("R6 aux kept", {7'd0, aux_carry}, 8'h01);
    endtask

    task automatic t_unary;
        run(C_LOAD, 8'hFF); run(C_INC, 8'h00); check("R5 inc wrap", acc, 8'h00);
        run(C_DEC, 8'h00); check("R5 dec wrap", acc, 8'hFF);
        run(C_CPL, 8'h00); check("R5 cpl", acc, 8'h00);
        run(C_LOAD, 8'h3C); run(C_CLR, 8'h77); check("R5 clr", acc, 8'h00);
        check("R6 carry after unary", {7'd0, carry}, 8'h01);
    endtask

    task automatic t_idle;
        run(C_LOAD, 8'h5A);
        run(C_CLR, 8'h00, 1'b0);
        check("R2 exec low", acc, 8'h5A);
        run(C_NOP, 8'hFF);
        check("R2 nop", acc, 8'h5A);
        check("R2 carry held", {7'd0, carry}, 8'h01);
    endtask

    task automatic t_rotate;
        run(C_LOAD, 8'h01); run(C_ADD, 8'h01);   // carry 0
        run(C_LOAD, 8'h81);
        run(C_RLC, 8'h00);
        check("R7 rlc acc", acc, 8'h02);
        check("R7 rlc carry", {7'd0, carry}, 8'h01);
        run(C_RRC, 8'h00);
        check("R7 rrc acc", acc, 8'h81);
        check("R7 rrc carry", {7'd0, carry}, 8'h00);
        run(C_RL, 8'h00); check("R7 rl", acc, 8'h03);
        run(C_RR, 8'h00); check("R7 rr", acc, 8'h81);
        check("R6 rotate keeps carry", {7'd0, carry}, 8'h00);
    endtask

    task automatic t_swap_xchd;
        run(C_LOAD, 8'hA5);
        @(negedge clk); operand = 8'h3C; #1;
        check("R9 xchg_out", xchg_out, 8'h35);
        run(C_XCHD, 8'h3C); check("R9 xchd acc", acc, 8'hAC);
        run(C_SWAP, 8'h00); check("R8 swap", acc, 8'hCA);
    endtask

    task automatic t_da;
        run(C_LOAD, 8'h15); run(C_ADD, 8'h27); run(C_DA, 8'h00);
        check("R10 15+27", acc, 8'h42);
        check("R10 15+27 carry", {7'd0, carry}, 8'h00);
        run(C_LOAD, 8'h99); run(C_ADD, 8'h99); run(C_DA, 8'h00);
        check("R10 99+99", acc, 8'h98);
        check("R10 99+99 carry", {7'd0, carry}, 8'h01);
        run(C_LOAD, 8'h58); run(C_ADD, 8'h46); run(C_DA, 8'h00);
        check("R10 58+46", acc, 8'h04);
        check("R10 58+46 carry", {7'd0, carry}, 8'h01);
    endtask

    task automatic t_sub;
        run(C_LOAD, 8'h50); run(C_CPL, 8'h00); run(C_ADD, 8'h23); run(C_CPL, 8'h00);
        check("R12 50-23", acc, 8'h2D);
        run(C_LOAD, 8'h10); run(C_CPL, 8'h00); run(C_ADD, 8'h20); run(C_CPL, 8'h00);
        check("R12 10-20", acc, 8'hF0);
    endtask

    initial begin
        #5000000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #35; rst_n = 1'b1;
        @(negedge clk); #1;
        t_reset;
        t_add;
        t_logic;
        t_unary;
        t_idle;
        t_rotate;
        t_swap_xchd;
        t_da;
        t_sub;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule